// File: doc/BRIEF.md
# Integer ALU with Condition Flags

This block is the integer execution unit of a load-store RISC core. Each cycle it takes two 32-bit operands and an opcode, and it produces one result together with a write enable for the register file. The operations are add, subtract, reverse subtract, AND, OR, exclusive-or, bit clear and move. Add and subtract can take an immediate value in place of the second register operand.

A four-bit condition register holds the negative, zero, carry and overflow flags. The block loads this register on the clock edge, either when the caller asks for a flag update or when the operation is one of the four flag-only operations: compare, compare-negative, test and test-equivalence. Those four operations never assert the result write.

For logical operations the carry flag is taken from the carry-out of the external shifter, and the overflow flag keeps its old value. The flags are also presented in the top four bits of a status word.

Top module: `nzcv_alu`

## Requirements
- R1: Opcode 0 gives A+B and opcode 1 gives A-B, both modulo 2^32, with result_we high. When use_imm is high, these two opcodes use imm in place of B. Every other opcode ignores use_imm and imm.
- R2: Opcode 2 (reverse subtract) gives B-A with result_we high.
- R3: The logical opcodes have result_we high and give these results: 3 is A AND B, 4 is A OR B, 5 is A XOR B, 6 is A AND NOT B, 7 is B (move).
- R4: On a flag update, N takes bit 31 of the operation's value, and Z is 1 exactly when all 32 bits of that value are zero.
- R5: On an arithmetic flag update, C takes the carry out. For add (0) and compare-negative (9) this is the unsigned carry. For subtract (1), compare (8) and reverse subtract (2) it is the inverse of borrow, so it is 1 when the minuend is greater than or equal to the subtrahend as unsigned values.
- R6: On an arithmetic flag update, V is 1 exactly when the two's-complement result is out of the signed 32-bit range.
- R7: On a flag update by a logical opcode (3 to 7, 10, 11), C takes shift_cout and V keeps its previous value.
- R8: Opcodes 8 (A-B), 9 (A+B), 10 (A AND B) and 11 (A XOR B) update the flags whatever set_flags is, and hold result_we low.
- R9: For opcodes 0 to 7, the flags change only on a clock edge where set_flags is high.
- R10: flags is ordered {N,Z,C,V} from bit 3 down to bit 0. status carries flags in bits 31:28 and zero in all other bits.
- R11: While rst_n is low, the flags are cleared to 0000.
- R12: Opcodes 12 to 15 are undefined. They hold result_we low and leave the flags unchanged, even when set_flags is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| opcode | input | 4 | Operation select |
| opnd_a | input | 32 | First register operand |
| opnd_b | input | 32 | Second register operand |
| imm | input | 32 | Immediate operand |
| use_imm | input | 1 | Use imm as B for add and subtract |
| set_flags | input | 1 | Request a flag update |
| shift_cout | input | 1 | Shifter carry-out, used as C by logical operations |
| result | output | 32 | Operation value |
| result_we | output | 1 | Register-file write enable |
| flags | output | 4 | Condition flags {N,Z,C,V} |
| status | output | 32 | Status word with the flags in the top bits |

## Verification
A result write and a flag update can fall in the same cycle. The bench provokes this by driving set_flags high on random writing opcodes, so both effects of one operation are judged together: the result and result_we are sampled before the edge, and the flags are sampled after it.

A second overlap comes from the logical operations, which update C from the shifter while V must keep the value left by an earlier arithmetic overflow. The bench forces an overflowing add, follows it with a flag-setting logical operation, and checks that V stays 1 while C follows shift_cout.

// File: rtl/nzcv_alu.sv
module nzcv_alu #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   opcode,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [W-1:0] imm,
  input  logic         use_imm,
  input  logic         set_flags,
  input  logic         shift_cout,
  output logic [W-1:0] result,
  output logic         result_we,
  output logic [3:0]   flags,
  output logic [W-1:0] status
);

  localparam logic [3:0] OP_ADD = 4'd0, OP_SUB = 4'd1, OP_RSB = 4'd2,
                         OP_AND = 4'd3, OP_ORR = 4'd4, OP_EOR = 4'd5,
                         OP_BIC = 4'd6, OP_MOV = 4'd7, OP_CMP = 4'd8,
                         OP_CMN = 4'd9, OP_TST = 4'd10, OP_TEQ = 4'd11;

  logic [W-1:0] b_sel, add_x, add_y, logic_val;
  logic [W:0]   sum;
  logic         add_cin, is_arith, is_flag_only, is_valid, do_update, ovf;

  assign b_sel = (use_imm && (opcode == OP_ADD || opcode == OP_SUB)) ? imm : opnd_b;

  always_comb begin
    add_x   = opnd_a;
    add_y   = b_sel;
    add_cin = 1'b0;
    unique case (opcode)
      OP_SUB, OP_CMP: begin add_y = ~b_sel; add_cin = 1'b1; end
      OP_RSB:         begin add_x = b_sel; add_y = ~opnd_a; add_cin = 1'b1; end
      default: ;
    endcase
  end

  assign sum = {1'b0, add_x} + {1'b0, add_y} + {{W{1'b0}}, add_cin};
  assign ovf = (add_x[W-1] == add_y[W-1]) && (sum[W-1] != add_x[W-1]);

  always_comb begin
    unique case (opcode)
      OP_AND, OP_TST: logic_val = opnd_a & b_sel;
      OP_ORR:         logic_val = opnd_a | b_sel;
      OP_EOR, OP_TEQ: logic_val = opnd_a ^ b_sel;
      OP_BIC:         logic_val = opnd_a & ~b_sel;
      OP_MOV:         logic_val = b_sel;
      default:        logic_val = '0;
    endcase
  end

  assign is_arith     = opcode inside {OP_ADD, OP_SUB, OP_RSB, OP_CMP, OP_CMN};
  assign is_flag_only = opcode inside {OP_CMP, OP_CMN, OP_TST, OP_TEQ};
  assign is_valid     = opcode <= OP_TEQ;
  assign do_update    = is_valid && (set_flags || is_flag_only);

  assign result    = is_arith ? sum[W-1:0] : logic_val;
  assign result_we = is_valid && !is_flag_only;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flags <= 4'b0000;
    else if (do_update)
      flags <= {result[W-1], result == '0,
                is_arith ? sum[W] : shift_cout,
                is_arith ? ovf : flags[0]};
  end

  assign status = {flags, {(W-4){1'b0}}};

endmodule

// File: rtl/nzcv_alu_chk.sv
module nzcv_alu_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [3:0]   opcode,
  input logic         set_flags,
  input logic [W-1:0] result,
  input logic         result_we,
  input logic [3:0]   flags,
  input logic [W-1:0] status
);

  // R8
  flag_only_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode inside {4'd8, 4'd9, 4'd10, 4'd11}) |-> !result_we);

  // R12
  undefined_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode >= 4'd12) |-> !result_we);

  // R9
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_flags && opcode <= 4'd7) |=> $stable(flags));

  // R12
  undefined_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode >= 4'd12) |=> $stable(flags));

  // R4
  n_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode <= 4'd11 && (set_flags || opcode >= 4'd8)) |=> flags[3] == $past(result[W-1]));

  // R4
  z_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode <= 4'd11 && (set_flags || opcode >= 4'd8)) |=> flags[2] == ($past(result) == '0));

  // R7
  logic_v_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((opcode inside {[4'd3:4'd7]} && set_flags) || opcode inside {4'd10, 4'd11})
      |=> flags[0] == $past(flags[0]));

  // R10
  status_layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[W-1:W-4] == flags && status[W-5:0] == '0);

endmodule

bind nzcv_alu nzcv_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .opcode(opcode), .set_flags(set_flags),
  .result(result), .result_we(result_we), .flags(flags), .status(status)
);

// File: tb/nzcv_alu_bench.sv
module nzcv_alu_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [3:0]  opcode = '0;
  logic [31:0] opnd_a = '0, opnd_b = '0, imm = '0;
  logic        use_imm = 1'b0, set_flags = 1'b0, shift_cout = 1'b0;
  logic [31:0] result, status;
  logic        result_we;
  logic [3:0]  flags;

  int checks = 0, errors = 0;
  logic [3:0] mflags = 4'b0000;

  nzcv_alu u_nzcv_alu (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .imm(imm), .use_imm(use_imm), .set_flags(set_flags), .shift_cout(shift_cout),
    .result(result), .result_we(result_we), .flags(flags), .status(status)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] im, input logic ui, input logic sf, input logic sc);
    logic [31:0] bb, r;
    logic c, v, arith, upd, we;
    longint unsigned ua, ub;
    longint sa, sb, ss;
    @(negedge clk);
    check("R9/R10 flags", flags, mflags);
    check("R10 status", status, {mflags, 28'h0});
    opcode = op; opnd_a = a; opnd_b = b; imm = im; use_imm = ui;
    set_flags = sf; shift_cout = sc;
    bb = (ui && (op == 4'd0 || op == 4'd1)) ? im : b;
    ua = longint'(a); ub = longint'(bb);
    sa = longint'($signed(a)); sb = longint'($signed(bb));
    arith = 1'b1; c = sc; v = mflags[0]; ss = 0; r = '0;
    case (op)
      4'd0, 4'd9: begin r = a + bb; c = (ua + ub) > 64'hFFFF_FFFF; ss = sa + sb; end
      4'd1, 4'd8: begin r = a - bb; c = ua >= ub; ss = sa - sb; end
      4'd2:       begin r = bb - a; c = ub >= ua; ss = sb - sa; end
      default: begin
        arith = 1'b0;
        case (op)
          4'd3, 4'd10: r = a & bb;
          4'd4:        r = a | bb;
          4'd5, 4'd11: r = a ^ bb;
          4'd6:        r = a & ~bb;
          4'd7:        r = bb;
          default:     r = '0;
        endcase
      end
    endcase
    if (arith) v = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
    we  = op <= 4'd7;
    upd = (op <= 4'd11) && (sf || op >= 4'd8);
    #1;
    check(op >= 4'd12 ? "R12 we" : (op >= 4'd8 ? "R8 we" : "R1/R2/R3 we"), result_we, we);
    if (we) check("R1/R2/R3 result", result, r);
    if (upd) mflags = {r[31], r == 32'h0, c, v};
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*2 + 1);
    check("R11 reset flags", flags, 0);
    check("R11 reset status", status, 0);
    @(negedge clk); rst_n = 1'b1;
    // R1 add / immediate, R5 carry, R4 zero
    step(4'd0, 32'hFFFF_FFFF, 32'h1, 32'h0, 0, 1, 0);
    step(4'd0, 32'h10, 32'h5, 32'h100, 1, 1, 0);
    // R6 overflow then R7 logical keeps V, C from shifter
    step(4'd0, 32'h7FFF_FFFF, 32'h1, 0, 0, 1, 0);
    step(4'd3, 32'hF0F0_0000, 32'hFF00_0000, 0, 0, 1, 1);
    step(4'd6, 32'hFFFF_FFFF, 32'h0000_FFFF, 0, 0, 1, 0);
    // R5 subtract borrow, R2 reverse subtract
    step(4'd1, 32'h3, 32'h5, 0, 0, 1, 0);
    step(4'd1, 32'h5, 32'h5, 0, 0, 1, 0);
    step(4'd2, 32'h3, 32'h5, 0, 0, 1, 0);
    step(4'd2, 32'h8000_0000, 32'h1, 0, 0, 1, 0);
    // R8 compare-type ops without set_flags; R1 ignored imm on compare
    step(4'd8, 32'h4, 32'h4, 32'hDEAD, 1, 0, 0);
    step(4'd9, 32'h8000_0000, 32'h8000_0000, 0, 0, 0, 0);
    step(4'd10, 32'hAAAA_AAAA, 32'h5555_5555, 0, 0, 0, 1);
    step(4'd11, 32'h1234_5678, 32'h1234_5679, 0, 0, 0, 0);
    // R9 no update without set_flags, R3 moves
    step(4'd7, 32'h0, 32'h0, 0, 0, 0, 1);
    step(4'd4, 32'h0, 32'h8000_0000, 0, 0, 0, 0);
    step(4'd5, 32'hFFFF_0000, 32'h0F0F_0F0F, 32'h1, 1, 0, 0);
    // R12 undefined opcodes
    step(4'd12, 32'h0, 32'h0, 0, 0, 1, 1);
    step(4'd15, 32'h1, 32'h1, 0, 0, 1, 0);
    for (int i = 0; i < 400; i++)
      step(4'($urandom_range(0, 15)), $urandom, ($urandom_range(0, 3) == 0) ? 32'h8000_0000 : $urandom,
           $urandom, 1'($urandom), 1'($urandom), 1'($urandom));
    @(negedge clk);
    check("R9 final flags", flags, mflags);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule